// File: doc/BRIEF.md
# Slowdown-Bound Bandwidth Allocation Controller

This block closes a feedback loop around one latency-critical application that shares main memory with other agents. Once per measurement interval an upstream estimator hands it a fixed-point slowdown figure for that application. The block compares the figure against a target bound widened by a tolerance on each side. Every N intervals it moves a bandwidth allocation up or down by a fixed step. The allocation is a count of reserved slots out of a 64-slot scheduler window. The memory scheduler reserves that many slots for the critical application and leaves the remainder to every other requester.

When the estimate stays above the tolerance band for N intervals in a row, the block raises a sticky alert for system software. Software can then migrate or de-schedule work. The alert stays up until software clears it.

The controller has three states. In `ST_IDLE` nothing is reserved and estimates are ignored. In `ST_TRACK` it counts intervals and misses. `ST_ADJUST` lasts one cycle and applies the step chosen at the Nth interval. The transitions are:
- IDLE→TRACK on `start`.
- TRACK→ADJUST when the Nth estimate is accepted.
- ADJUST→TRACK always.
- Any state→TRACK on `start`, which reloads the allocation.

Estimate pulses are expected at most once every two cycles. A pulse that lands in the ADJUST cycle is dropped.

Top module: `slowdown_alloc_ctrl`

## Requirements
- R1: After reset the allocation output is 0, the alert is low and the controller is idle.
- R2: A `start` pulse loads `cfg_init` clamped to the range [min, max], where max is `cfg_max` limited to 64 and min is `cfg_min` limited to that max. The loaded value is visible after the sampling edge.
- R3: The allocation changes only on evaluation, which happens on every Nth accepted estimate (N = `cfg_period`, 0 treated as 1) and uses that Nth estimate. The new value appears one clock edge after the edge that samples the Nth estimate; between evaluations the allocation holds.
- R4: An evaluated estimate strictly greater than bound + tol raises the allocation by `cfg_step`, saturating at max.
- R5: An evaluated estimate for which estimate + tol is strictly less than bound (the lower band edge, floored at 0) lowers the allocation by `cfg_step`, saturating at min.
- R6: An evaluated estimate inside the closed band leaves the allocation unchanged.
- R7: The alert rises on the edge that samples the Nth consecutive estimate above bound + tol. Any estimate at or below bound + tol resets the run count, and the count restarts from zero after each raise.
- R8: The alert is sticky until `alert_clear`. If a raise and a clear coincide, the alert ends up set.
- R9: `start` while tracking reloads the clamped initial allocation and restarts the interval and miss counts, without touching the alert.
- R10: Estimates arriving while idle are ignored: they move neither the allocation nor the alert, nor any count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load initial allocation and begin or restart tracking |
| est_valid | input | 1 | One-cycle pulse marking a new interval estimate |
| est_slowdown | input | EST_W | Unsigned fixed-point slowdown estimate |
| cfg_bound | input | EST_W | Target slowdown bound, same format |
| cfg_tol | input | EST_W | Tolerance on either side of the bound |
| cfg_period | input | CNT_W | Intervals per evaluation and miss run length (0 means 1) |
| cfg_init | input | AW | Initial allocation in slots |
| cfg_min | input | AW | Lowest allocation |
| cfg_max | input | AW | Highest allocation (limited to SLOTS) |
| cfg_step | input | AW | Step per evaluation |
| alert_clear | input | 1 | Clears the sticky alert |
| alloc_slots | output | AW | Reserved slots out of SLOTS |
| alert | output | 1 | Sticky notification of a sustained bound miss |

## Verification
Assertions check properties that hold on every cycle:
- Idle implies zero reservation, and the allocation never exceeds the window.
- The allocation is stable throughout tracking, and ADJUST lasts exactly one cycle.
- An up decision never lowers the allocation, a down decision never raises it, and a hold keeps it.
- The alert stays up until cleared, and it only rises right after a sampled over-bound estimate.

Only the bench scenarios can show the rest: the exact step sizes and saturation points, that evaluation falls on precisely the Nth estimate, the miss-run reset on an in-band interval, the clamping of the initial value, restart behaviour, and the precedence of set over clear. The bench sweeps period, step, band width and limits through long runs of over-, in- and under-band estimates against an arithmetic model.

// File: rtl/slb_pkg.sv
package slb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_TRACK  = 2'd1,
        ST_ADJUST = 2'd2
    } ctrl_state_t;

    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } step_dir_t;
endpackage

// File: rtl/slb_band_classifier.sv
module slb_band_classifier
    import slb_pkg::*;
#(
    parameter int EST_W = 16
) (
    input  logic [EST_W-1:0] est,
    input  logic [EST_W-1:0] bound,
    input  logic [EST_W-1:0] tol,
    output step_dir_t        dir,
    output logic             over
);
    logic [EST_W:0] hi_edge;
    logic [EST_W:0] est_plus_tol;
    logic           under;

    // Widen by one bit so neither edge wraps; lower edge floors at zero.
    assign hi_edge      = {1'b0, bound} + {1'b0, tol};
    assign est_plus_tol = {1'b0, est} + {1'b0, tol};
    assign over         = {1'b0, est} > hi_edge;
    assign under        = est_plus_tol < {1'b0, bound};

    always_comb begin
        if (over)       dir = DIR_UP;
        else if (under) dir = DIR_DOWN;
        else            dir = DIR_HOLD;
    end
endmodule

// File: rtl/slb_alloc_stepper.sv
module slb_alloc_stepper
    import slb_pkg::*;
#(
    parameter int SLOTS = 64,
    localparam int AW   = $clog2(SLOTS + 1)
) (
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] init,
    input  logic [AW-1:0] step,
    input  logic [AW-1:0] lo_cfg,
    input  logic [AW-1:0] hi_cfg,
    input  step_dir_t     dir,
    output logic [AW-1:0] nxt,
    output logic [AW-1:0] init_clamped
);
    localparam logic [AW-1:0] SLOTS_V = AW'(SLOTS);

    logic [AW-1:0] hi_eff;
    logic [AW-1:0] lo_eff;
    logic [AW:0]   up_sum;
    logic [AW:0]   down_floor;

    assign hi_eff     = (hi_cfg > SLOTS_V) ? SLOTS_V : hi_cfg;
    assign lo_eff     = (lo_cfg > hi_eff) ? hi_eff : lo_cfg;
    assign up_sum     = {1'b0, cur} + {1'b0, step};
    assign down_floor = {1'b0, lo_eff} + {1'b0, step};

    always_comb begin
        if (init < lo_eff)      init_clamped = lo_eff;
        else if (init > hi_eff) init_clamped = hi_eff;
        else                    init_clamped = init;
    end

    always_comb begin
        case (dir)
            DIR_UP:   nxt = (up_sum > {1'b0, hi_eff}) ? hi_eff : up_sum[AW-1:0];
            DIR_DOWN: nxt = ({1'b0, cur} < down_floor) ? lo_eff : cur - step;
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/slb_miss_tracker.sv
module slb_miss_tracker #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             sample,
    input  logic             over,
    input  logic [CNT_W-1:0] run_len,
    input  logic             clear,
    output logic             alert
);
    logic [CNT_W-1:0] miss_q;
    logic [CNT_W:0]   bump;
    logic             hit;

    assign bump = {1'b0, miss_q} + 1'b1;
    assign hit  = sample && over && (bump >= {1'b0, run_len});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            miss_q <= '0;
        end else if (restart) begin
            miss_q <= '0;
        end else if (sample) begin
            if (!over || hit) miss_q <= '0;
            else              miss_q <= bump[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     alert <= 1'b0;
        else if (hit)   alert <= 1'b1;
        else if (clear) alert <= 1'b0;
    end

    AST_ALERT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (alert && !clear) |=> alert); // R8
    AST_ALERT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alert) |-> $past(sample && over)); // R7
endmodule

// File: rtl/slowdown_alloc_ctrl.sv
module slowdown_alloc_ctrl
    import slb_pkg::*;
#(
    parameter int SLOTS = 64,
    parameter int EST_W = 16,
    parameter int CNT_W = 8,
    localparam int AW   = $clog2(SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             est_valid,
    input  logic [EST_W-1:0] est_slowdown,
    input  logic [EST_W-1:0] cfg_bound,
    input  logic [EST_W-1:0] cfg_tol,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [AW-1:0]    cfg_init,
    input  logic [AW-1:0]    cfg_min,
    input  logic [AW-1:0]    cfg_max,
    input  logic [AW-1:0]    cfg_step,
    input  logic             alert_clear,
    output logic [AW-1:0]    alloc_slots,
    output logic             alert
);
    ctrl_state_t      state_q, state_d;
    step_dir_t        dir_now, dir_q;
    logic             over_now;
    logic [CNT_W-1:0] n_eff;
    logic [CNT_W-1:0] int_q;
    logic [CNT_W:0]   int_bump;
    logic             take;
    logic             last;
    logic [AW-1:0]    alloc_q;
    logic [AW-1:0]    alloc_next;
    logic [AW-1:0]    alloc_init;

    assign n_eff    = (cfg_period == '0) ? CNT_W'(1) : cfg_period;
    assign int_bump = {1'b0, int_q} + 1'b1;
    assign take     = est_valid && (state_q == ST_TRACK) && !start;
    assign last     = take && (int_bump == {1'b0, n_eff});

    slb_band_classifier #(.EST_W(EST_W)) u_band (
        .est   (est_slowdown),
        .bound (cfg_bound),
        .tol   (cfg_tol),
        .dir   (dir_now),
        .over  (over_now)
    );

    slb_alloc_stepper #(.SLOTS(SLOTS)) u_step (
        .cur          (alloc_q),
        .init         (cfg_init),
        .step         (cfg_step),
        .lo_cfg       (cfg_min),
        .hi_cfg       (cfg_max),
        .dir          (dir_q),
        .nxt          (alloc_next),
        .init_clamped (alloc_init)
    );

    slb_miss_tracker #(.CNT_W(CNT_W)) u_miss (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start),
        .sample  (take),
        .over    (over_now),
        .run_len (n_eff),
        .clear   (alert_clear),
        .alert   (alert)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = start ? ST_TRACK : ST_IDLE;
            ST_TRACK:  state_d = (!start && last) ? ST_ADJUST : ST_TRACK;
            ST_ADJUST: state_d = ST_TRACK;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Interval counter and latched decision
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_q <= '0;
            dir_q <= DIR_HOLD;
        end else if (start) begin
            int_q <= '0;
            dir_q <= DIR_HOLD;
        end else if (take) begin
            int_q <= last ? '0 : int_bump[CNT_W-1:0];
            if (last) dir_q <= dir_now;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     alloc_q <= '0;
        else if (start)                 alloc_q <= alloc_init;
        else if (state_q == ST_ADJUST)  alloc_q <= alloc_next;
    end

    assign alloc_slots = alloc_q;

    AST_IDLE_NO_RESERVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (alloc_q == '0)); // R1
    AST_ALLOC_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_q <= AW'(SLOTS)); // R2
    AST_HOLD_WHILE_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRACK && !start) |=> $stable(alloc_q)); // R3
    AST_ADJUST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADJUST) |=> (state_q == ST_TRACK)); // R3
    AST_UP_NOT_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADJUST && dir_q == DIR_UP && !start) |=> (alloc_q >= $past(alloc_q))); // R4
    AST_DOWN_NOT_HIGHER: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADJUST && dir_q == DIR_DOWN && !start) |=> (alloc_q <= $past(alloc_q))); // R5
    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADJUST && dir_q == DIR_HOLD && !start) |=> $stable(alloc_q)); // R6
endmodule

// File: tb/slowdown_alloc_ctrl_bench.sv
`timescale 1ns/1ps
module slowdown_alloc_ctrl_bench;
    localparam int SLOTS = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        est_valid = 1'b0;
    logic [15:0] est_slowdown = '0;
    logic [15:0] cfg_bound = 16'h0200;
    logic [15:0] cfg_tol = 16'h0020;
    logic [7:0]  cfg_period = 8'd1;
    logic [6:0]  cfg_init = 7'd20;
    logic [6:0]  cfg_min = 7'd8;
    logic [6:0]  cfg_max = 7'd40;
    logic [6:0]  cfg_step = 7'd4;
    logic        alert_clear = 1'b0;
    logic [6:0]  alloc_slots;
    logic        alert;

    int n_cmp = 0;
    int n_bad = 0;
    int m_alloc = 0, m_alert = 0, m_int = 0, m_miss = 0, m_run = 0;

    always #2.5 clk = ~clk;

    slowdown_alloc_ctrl u_slowdown_alloc_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .est_valid(est_valid),
        .est_slowdown(est_slowdown), .cfg_bound(cfg_bound), .cfg_tol(cfg_tol),
        .cfg_period(cfg_period), .cfg_init(cfg_init), .cfg_min(cfg_min),
        .cfg_max(cfg_max), .cfg_step(cfg_step), .alert_clear(alert_clear),
        .alloc_slots(alloc_slots), .alert(alert)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int hi_lim();
        return (int'(cfg_max) > SLOTS) ? SLOTS : int'(cfg_max);
    endfunction

    function automatic int lo_lim();
        return (int'(cfg_min) > hi_lim()) ? hi_lim() : int'(cfg_min);
    endfunction

    task automatic do_start(input string tag);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        m_alloc = int'(cfg_init);
        if (m_alloc < lo_lim()) m_alloc = lo_lim();
        if (m_alloc > hi_lim()) m_alloc = hi_lim();
        m_int = 0; m_miss = 0; m_run = 1;
        chk(tag, alloc_slots, m_alloc);
    endtask

    task automatic clear_alert();
        @(negedge clk) alert_clear = 1'b1;
        @(negedge clk) alert_clear = 1'b0;
        m_alert = 0;
        chk("R8 clear", alert, 0);
    endtask

    task automatic send_est(input int e, input bit clr);
        int    prev, neff, hi, lo;
        bit    over, under, eval;
        string tag;
        prev = m_alloc; eval = 0; tag = m_run ? "R3" : "R10";
        @(negedge clk) begin est_slowdown = 16'(e); est_valid = 1'b1; alert_clear = clr; end
        @(negedge clk) begin est_valid = 1'b0; alert_clear = 1'b0; end
        if (clr) m_alert = 0;
        if (m_run) begin
            neff  = (cfg_period == 0) ? 1 : int'(cfg_period);
            over  = e > int'(cfg_bound) + int'(cfg_tol);
            under = e + int'(cfg_tol) < int'(cfg_bound);
            if (over) begin
                m_miss++;
                if (m_miss >= neff) begin m_alert = 1; m_miss = 0; end
            end else m_miss = 0;
            m_int++;
            if (m_int == neff) begin
                m_int = 0; eval = 1;
                hi = hi_lim(); lo = lo_lim();
                if (over) begin
                    tag = "R4";
                    m_alloc = (m_alloc + int'(cfg_step) > hi) ? hi : m_alloc + int'(cfg_step);
                end else if (under) begin
                    tag = "R5";
                    m_alloc = (m_alloc < lo + int'(cfg_step)) ? lo : m_alloc - int'(cfg_step);
                end else tag = "R6";
            end
        end
        chk(m_run ? "R7 alert" : "R10 alert", alert, m_alert);
        chk("R3 no early change", alloc_slots, prev);
        @(negedge clk);
        chk(tag, alloc_slots, m_alloc);
    endtask

    function automatic int pick(input int i);
        int b, t;
        b = int'(cfg_bound); t = int'(cfg_tol);
        if (i < 14) return (i % 2 == 1) ? 16'hFFFF : b + t + 1;
        if (i < 18) begin
            if (i % 3 == 0) return b + t;
            if (i % 3 == 1) return (t <= b) ? b - t : 0;
            return b;
        end
        if (i < 36) return (i % 2 == 1) ? 0 : ((t < b) ? b - t - 1 : 0);
        return b;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 alloc", alloc_slots, 0);
        chk("R1 alert", alert, 0);

        // R10: idle estimates ignored
        cfg_period = 8'd1;
        for (int i = 0; i < 3; i++) send_est(16'hFFFF, 1'b0);

        for (int np = 0; np < 4; np++)
            for (int sv = 0; sv < 3; sv++)
                for (int bw = 0; bw < 2; bw++) begin
                    cfg_period = 8'(np);
                    cfg_step   = (sv == 0) ? 7'd1 : (sv == 1) ? 7'd5 : 7'd13;
                    cfg_tol    = (bw == 0) ? 16'h0020 : 16'h0300;
                    cfg_max    = (bw == 0) ? 7'd40 : 7'd100;
                    cfg_init   = (sv == 2) ? 7'd90 : (sv == 1 ? 7'd2 : 7'd20);
                    clear_alert();
                    do_start("R2");
                    for (int i = 0; i < 40; i++) send_est(pick(i), 1'b0);
                end

        // R9: restart mid-tracking
        cfg_period = 8'd3; cfg_step = 7'd4; cfg_tol = 16'h0020;
        cfg_max = 7'd40; cfg_init = 7'd20;
        clear_alert();
        do_start("R2");
        send_est(16'h0300, 1'b0);
        send_est(16'h0300, 1'b0);
        do_start("R9 restart");
        send_est(16'h0300, 1'b0);
        send_est(16'h0300, 1'b0);
        chk("R9 counts restarted", alloc_slots, 20);
        chk("R9 alert untouched", alert, 0);
        send_est(16'h0300, 1'b0);

        // R8: raise and clear together, raise wins
        cfg_period = 8'd1;
        clear_alert();
        do_start("R2");
        send_est(16'h0300, 1'b1);
        chk("R8 set wins", alert, 1);
        clear_alert();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule